// File: doc/BRIEF.md
# I2C Slave Register Port with Descending Read Pointer

This block is the two-wire serial slave of a sensor-style device. It watches the clock and data lines, finds start, repeated start and stop conditions, and answers only to its own 7-bit device address. A write transfer loads an internal register pointer from its first payload byte. Every later byte in that transfer goes out as a one-cycle write strobe to the register bank, which sits outside this block.

A read transfer returns the register that the pointer selects, most significant bit first. Each byte loaded for transmission moves the pointer down by one, including when only one byte is read. The descent skips a hole in the register map: from 0x0C it goes straight to 0x11. A disable input makes the slave ignore the bus, so it can share its pins with a chip-select serial bus. A separate hold register copies a live data word only while chip-select is high and keeps its value while chip-select is low.

Top module: `sensRegI2c`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {6'b001111, addrStrap}, which is 0x1E or 0x1F. After any other address byte it never pulls the data line low, and it stays idle until the next start condition.
- R2: In a write transfer (R/W bit 0), the first byte after the address byte is acknowledged and becomes the pointer. The pointer is visible on regAddr.
- R3: Each later byte of a write transfer is acknowledged and produces exactly one regWrEn pulse, with that byte on regWrData and the pointer on regAddr. The pointer does not change on writes.
- R4: In a read transfer (R/W bit 1), each byte sent is the value of regRdData at the current pointer, MSB first. Loading the byte moves the pointer to pointer-1, and 0x00 wraps to 0xFF.
- R5: When a read byte is loaded with the pointer at 0x0C, the pointer becomes 0x11.
- R6: When the master does not acknowledge a read byte, the slave releases the data line and sends nothing more until a new start condition.
- R7: A read address byte that arrives before any pointer has been loaded since reset is not acknowledged.
- R8: A repeated start condition restarts the address phase at any point and keeps the pointer. A stop condition returns the slave to idle.
- R9: While i2cDisable is high, bus activity has no effect: no acknowledge, no write strobe and no pointer change.
- R10: heldData copies liveData on every clock while csN is high, and holds its value while csN is low.
- R11: sdaOe changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | 1 pulls the data line low (open drain) |
| addrStrap | input | 1 | Level of the strap pin that sets the address LSB |
| i2cDisable | input | 1 | 1 makes the slave ignore the bus |
| regAddr | output | 8 | Register pointer |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Write data for the register at regAddr |
| regRdData | input | 8 | Register bank contents at regAddr |
| csN | input | 1 | Chip-select, active low |
| liveData | input | HOLD_W | Incoming data word |
| heldData | output | HOLD_W | Data word, frozen while csN is low |

## Verification
The bench sweeps all 128 address bytes against both strap levels. A design that decodes the address wrongly either acknowledges foreign addresses or misses its own. It then loads every pointer from 0x00 to 0x1F, plus 0xFE and 0xFF, and reads three bytes from each. This catches an ascending pointer, a pointer that skips the decrement on the first byte, a misplaced gap jump, and a wrong wrap at zero. Further cases cover a read before any pointer has been loaded, the silence after a master not-acknowledge, a pointer kept across a repeated start, a write burst that must not move the pointer, the disable input, and the hold register freezing while chip-select is low.

// File: rtl/sensRegI2cPkg.sv
package sensRegI2cPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_READ,
    ST_MACK,
    ST_RDNEXT
  } busState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic loadPtr;   // received byte becomes the pointer
    logic writeReg;  // received byte goes to the register bank
    logic loadTx;    // fetch a byte to send and step the pointer down
    logic shiftTx;   // present the next transmit bit
  } dpStrobe_t;

  function automatic logic [7:0] stepDown(input logic [7:0] cur,
                                          input logic [7:0] gapHigh,
                                          input logic [7:0] gapLow);
    if (cur == gapHigh) return gapLow;
    return cur - 8'd1;
  endfunction

endpackage

// File: rtl/sensRegI2cSync.sv
module sensRegI2cSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= scl;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[STAGES-2:0], scl};
          sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS      = sclPipe[STAGES-1];
  assign sdaS      = sdaPipe[STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/sensRegI2cCtrl.sv
module sensRegI2cCtrl
  import sensRegI2cPkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b001111
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startCond,
  input  logic      stopCond,
  input  logic      i2cDisable,
  input  logic      addrStrap,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  input  logic      ptrValid,
  output dpStrobe_t strb,
  output logic      sdaOe
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  busState_e state;
  busState_e afterAck;
  logic [3:0] bitCnt;
  logic byteDone;
  logic addrHit;
  logic busLive;

  assign byteDone = sclFall && (bitCnt == BYTE_BITS);
  assign addrHit  = (rxByte[7:1] == {DEV_ADDR_HI, addrStrap});
  assign busLive  = !i2cDisable && !stopCond && !startCond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
    end else if (i2cDisable || stopCond) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (startCond) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && bitCnt != BYTE_BITS) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (addrHit && (!rxByte[0] || ptrValid)) begin
                state    <= ST_ACK;
                afterAck <= rxByte[0] ? ST_READ : ST_PTR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state    <= ST_ACK;
              afterAck <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            state  <= afterAck;
            bitCnt <= '0;
          end
        end
        ST_READ: begin
          if (sclRise && bitCnt != BYTE_BITS) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            state  <= ST_MACK;
          end
        end
        ST_MACK: begin
          if (sclRise) state <= sdaS ? ST_IDLE : ST_RDNEXT;
        end
        ST_RDNEXT: begin
          if (sclFall) state <= ST_READ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.shiftIn  = busLive && sclRise && (bitCnt != BYTE_BITS) &&
                    (state == ST_ADDR || state == ST_PTR || state == ST_WDATA);
    strb.loadPtr  = busLive && byteDone && (state == ST_PTR);
    strb.writeReg = busLive && byteDone && (state == ST_WDATA);
    strb.loadTx   = busLive && sclFall &&
                    ((state == ST_ACK && afterAck == ST_READ) || state == ST_RDNEXT);
    strb.shiftTx  = busLive && sclFall && (state == ST_READ) && (bitCnt != BYTE_BITS);
  end

  assign sdaOe = (state == ST_ACK) || (state == ST_READ && !txMsb);

  // R11: the driven data line moves only while the clock line is low
  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclS));

  // R9: a disabled slave lets go of the line
  assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    i2cDisable |=> !sdaOe);

  // R7: a read acknowledge only exists once a pointer has been loaded
  assert_read_needs_ptr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && afterAck == ST_READ) |-> ptrValid);

  assert_bitcnt_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BYTE_BITS);
endmodule

// File: rtl/sensRegI2cData.sv
module sensRegI2cData
  import sensRegI2cPkg::*;
#(
  parameter logic [7:0] GAP_HIGH = 8'h0C,
  parameter logic [7:0] GAP_LOW  = 8'h11,
  parameter int         HOLD_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaS,
  input  logic [7:0]        regRdData,
  input  logic              csN,
  input  logic [HOLD_W-1:0] liveData,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic              ptrValid,
  output logic [7:0]        regAddr,
  output logic              regWrEn,
  output logic [7:0]        regWrData,
  output logic [HOLD_W-1:0] heldData
);
  logic [7:0] rxSh;
  logic [7:0] txSh;
  logic [7:0] ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh      <= '0;
      txSh      <= '1;
      ptr       <= '0;
      ptrValid  <= 1'b0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      regWrEn <= strb.writeReg;
      if (strb.shiftIn) rxSh <= {rxSh[6:0], sdaS};
      if (strb.writeReg) regWrData <= rxSh;
      if (strb.loadPtr) begin
        ptr      <= rxSh;
        ptrValid <= 1'b1;
      end else if (strb.loadTx) begin
        ptr <= stepDown(ptr, GAP_HIGH, GAP_LOW);
      end
      if (strb.loadTx) txSh <= regRdData;
      else if (strb.shiftTx) txSh <= {txSh[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) heldData <= '0;
    else if (csN) heldData <= liveData;
  end

  assign rxByte  = rxSh;
  assign txMsb   = txSh[7];
  assign regAddr = ptr;

  // R5: the descent jumps across the register gap
  assert_gap_jump_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && !strb.loadPtr && ptr == GAP_HIGH) |=> (ptr == GAP_LOW));

  // R10: hold register frozen while chip-select is low
  assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> $stable(heldData));

  // R3: no write strobe before a pointer exists
  assert_write_after_ptr_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> ptrValid);

  // R3: writes never move the pointer
  assert_write_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $stable(regAddr));
endmodule

// File: rtl/sensRegI2c.sv
module sensRegI2c
  import sensRegI2cPkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b001111,
  parameter logic [7:0] GAP_HIGH    = 8'h0C,
  parameter logic [7:0] GAP_LOW     = 8'h11,
  parameter int         SYNC_STAGES = 2,
  parameter int         HOLD_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              addrStrap,
  input  logic              i2cDisable,
  output logic [7:0]        regAddr,
  output logic              regWrEn,
  output logic [7:0]        regWrData,
  input  logic [7:0]        regRdData,
  input  logic              csN,
  input  logic [HOLD_W-1:0] liveData,
  output logic [HOLD_W-1:0] heldData
);
  logic sclS, sdaS, sclRise, sclFall, startCond, stopCond;
  logic [7:0] rxByte;
  logic txMsb, ptrValid;
  dpStrobe_t strb;

  sensRegI2cSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  sensRegI2cCtrl #(.DEV_ADDR_HI(DEV_ADDR_HI)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond),
    .i2cDisable(i2cDisable), .addrStrap(addrStrap),
    .rxByte(rxByte), .txMsb(txMsb), .ptrValid(ptrValid),
    .strb(strb), .sdaOe(sdaOe)
  );

  sensRegI2cData #(.GAP_HIGH(GAP_HIGH), .GAP_LOW(GAP_LOW), .HOLD_W(HOLD_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaS),
    .regRdData(regRdData), .csN(csN), .liveData(liveData),
    .rxByte(rxByte), .txMsb(txMsb), .ptrValid(ptrValid),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .heldData(heldData)
  );
endmodule

// File: tb/test_sensRegI2c.sv
module test_sensRegI2c;
  localparam int HW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic addrStrap = 1'b0;
  logic i2cDisable = 1'b0;
  logic [7:0] regAddr, regWrData, regRdData;
  logic regWrEn;
  logic csN = 1'b1;
  logic [HW-1:0] liveData = '0;
  logic [HW-1:0] heldData;
  logic sdaLine;

  int errors = 0;
  int checks = 0;
  int wrCount = 0;
  int edgeViolations = 0;
  logic [7:0] wrAddrLog [4];
  logic [7:0] wrDataLog [4];
  bit done = 0;

  always #10 clk = ~clk;

  assign sdaLine   = mSda & ~sdaOe;
  assign regRdData = regAddr ^ 8'hA5;

  sensRegI2c i_sensRegI2c (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrStrap(addrStrap), .i2cDisable(i2cDisable),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .csN(csN), .liveData(liveData), .heldData(heldData)
  );

  logic prevOe = 1'b0;
  always @(posedge clk) begin
    if (regWrEn) begin
      if (wrCount < 4) begin
        wrAddrLog[wrCount] <= regAddr;
        wrDataLog[wrCount] <= regWrData;
      end
      wrCount <= wrCount + 1;
    end
    if (rstN && sdaOe != prevOe && scl) edgeViolations <= edgeViolations + 1;
    prevOe <= sdaOe;
  end

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p == 8'h0C) ? 8'h11 : p - 8'd1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(5); scl = 1'b1; tick(10); mSda = 1'b0; tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(5); scl = 1'b1; tick(10); mSda = 1'b1; tick(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(4); scl = 1'b1; tick(10); scl = 1'b0; tick(6);
    end
    mSda = 1'b1; tick(4); scl = 1'b1; tick(5);
    acked = !sdaLine;
    tick(5); scl = 1'b0; tick(6);
  endtask

  task automatic getByte(input bit giveAck, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(10); scl = 1'b1; tick(5); b = {b[6:0], sdaLine}; tick(5); scl = 1'b0;
    end
    mSda = giveAck ? 1'b0 : 1'b1; tick(4); scl = 1'b1; tick(10); scl = 1'b0; tick(6);
    mSda = 1'b1;
  endtask

  task automatic setPointer(input logic [7:0] p, output bit ok);
    bit a1, a2;
    busStart();
    sendByte({6'b001111, addrStrap, 1'b0}, a1);
    sendByte(p, a2);
    busStop();
    ok = a1 && a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack, ok;
    logic [7:0] b;
    logic [7:0] p;
    int wc;
    tick(5);
    rstN = 1'b1;
    tick(3);
    check(sdaOe == 1'b0 && regAddr == 8'h00 && regWrEn == 1'b0, "reset R1", sdaOe, 0);

    // R7: read before any pointer is loaded
    busStart();
    sendByte(8'h3D, ack);
    busStop();
    check(!ack, "R7 read before pointer", ack, 0);

    // R1: full address sweep against both strap levels
    for (int s = 0; s < 2; s++) begin
      addrStrap = s[0];
      for (int a = 0; a < 128; a++) begin
        busStart();
        sendByte({a[6:0], 1'b0}, ack);
        busStop();
        check(ack == (a[6:0] == {6'b001111, s[0]}), "R1 address match", ack, a);
      end
    end
    addrStrap = 1'b0;

    // R3: write burst
    setPointer(8'h20, ok);
    check(ok && regAddr == 8'h20, "R2 pointer load", regAddr, 8'h20);
    wc = wrCount;
    busStart();
    sendByte(8'h3C, ack);
    sendByte(8'h20, ok);
    sendByte(8'h5A, ack);
    check(ack, "R3 data ack", ack, 1);
    sendByte(8'h3C, ack);
    busStop();
    check(wrCount == wc + 2, "R3 write count", wrCount - wc, 2);
    check(wrAddrLog[0] == 8'h20 && wrDataLog[0] == 8'h5A, "R3 first write", wrDataLog[0], 8'h5A);
    check(wrAddrLog[1] == 8'h20 && wrDataLog[1] == 8'h3C, "R3 second write", wrDataLog[1], 8'h3C);
    check(regAddr == 8'h20, "R3 pointer kept", regAddr, 8'h20);

    // R2/R4/R5/R6: pointer sweep with three-byte reads
    for (int k = 0; k < 34; k++) begin
      p = (k < 32) ? k[7:0] : ((k == 32) ? 8'hFE : 8'hFF);
      setPointer(p, ok);
      check(ok && regAddr == p, "R2 pointer sweep", regAddr, p);
      busStart();
      sendByte(8'h3D, ack);
      check(ack, "R4 read address ack", ack, 1);
      for (int j = 0; j < 3; j++) begin
        getByte(j < 2, b);
        check(b == (p ^ 8'hA5), (p == 8'h0C || p == 8'h11) ? "R5 read data" : "R4 read data", b, p ^ 8'hA5);
        p = nxt(p);
      end
      // R6: after the not-acknowledge the slave stays silent
      getByte(1'b0, b);
      check(b == 8'hFF, "R6 silent after nack", b, 8'hFF);
      busStop();
      check(regAddr == p, "R4 pointer after read", regAddr, p);
    end

    // R8: repeated start keeps the pointer
    busStart();
    sendByte(8'h3C, ack);
    sendByte(8'h0C, ack);
    busStart();
    sendByte(8'h3D, ack);
    check(ack, "R8 repeated start ack", ack, 1);
    getByte(1'b0, b);
    busStop();
    check(b == (8'h0C ^ 8'hA5), "R8 data after repeated start", b, 8'h0C ^ 8'hA5);
    check(regAddr == 8'h11, "R5 gap jump single read", regAddr, 8'h11);

    // R9: disabled slave ignores the bus
    i2cDisable = 1'b1;
    wc = wrCount;
    busStart();
    sendByte(8'h3C, ack);
    check(!ack, "R9 no ack when disabled", ack, 0);
    sendByte(8'h40, ok);
    sendByte(8'h77, ok);
    busStop();
    check(wrCount == wc && regAddr == 8'h11, "R9 no effect when disabled", regAddr, 8'h11);
    i2cDisable = 1'b0;
    tick(3);

    // R10: hold register
    csN = 1'b1; liveData = 16'hBEEF; tick(2);
    check(heldData == 16'hBEEF, "R10 tracks while high", heldData, 16'hBEEF);
    csN = 1'b0; tick(1); liveData = 16'h1234; tick(3);
    check(heldData == 16'hBEEF, "R10 frozen while low", heldData, 16'hBEEF);
    csN = 1'b1; tick(2);
    check(heldData == 16'h1234, "R10 refresh after release", heldData, 16'h1234);

    check(edgeViolations == 0, "R11 line change while clock high", edgeViolations, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule